// File: doc/BRIEF.md
# Fractional Ratio Strobe Generator

This block runs entirely on one root clock and turns it into a set of periodic one-cycle enable strobes. Each strobe stands for a slower derived domain. Logic in that domain advances only on cycles where its strobe is high. The derived rates are fixed fractions of the root: one third, one half, one quarter, and two in every five. A fifth output, meant for a flash controller, carries either the quarter-rate strobe or the two-in-five strobe. A select bit taken from a control register picks between them.

The quarter-rate strobe is chained from the half-rate strobe and has no counter of its own. It fires on every second half-rate pulse. The two-in-five strobe uses a five-cycle frame with pulses on frame positions 0 and 2, which spaces the pulses as evenly as five cycles allow. The select bit takes effect only on cycles where a five-cycle frame starts and a quarter pulse fires together, which happens once every 20 root cycles. Because of this, moving the select bit never produces a short or doubled flash pulse.

A small sequencer holds all strobes low through reset and through one settling cycle after reset. The sequencer has two states. In `ST_HOLD` it waits, and it always moves to `ST_RUN` on the first clock edge after reset is released. In `ST_RUN` the dividers advance, and the sequencer stays there until the next reset. The flash source selector has two states, `SRC_CORE` (follow the quarter strobe) and `SRC_FAST` (follow the two-in-five strobe). At each 20-cycle boundary it moves to `SRC_FAST` when the select bit is 1 and to `SRC_CORE` when the select bit is 0. At every other cycle it stays where it is.

Top module: `frac_strobe_gen`

## Requirements
- R1: While `rst_n` is low, every strobe output is 0. At the first rising edge after release, every strobe output is still driven to 0. From the second rising edge on, the strobes follow their patterns. The cycle after that second edge is frame cycle j = 0, and on it the third, half, quarter and two-in-five strobes are all 1.
- R2: `stb_third` is 1 exactly on frame cycles j with j mod 3 = 0.
- R3: `stb_half` is 1 exactly on frame cycles j with j mod 2 = 0.
- R4: `stb_quarter` is 1 on every second `stb_half` pulse, starting with the first one. That is, it is 1 exactly when j mod 4 = 0, and it is never 1 without `stb_half`.
- R5: `stb_two5` repeats the five-cycle pattern 1,0,1,0,0. It is 1 exactly when j mod 5 is 0 or 2.
- R6: `stb_flash` equals `stb_two5` while the latched select is 1, and equals `stb_quarter` while the latched select is 0.
- R7: `flash_fast_sel` is latched only on cycles with j mod 20 = 0. A change of the select bit at any other time has no effect on `stb_flash` until the next such cycle.
- R8: Over the first 60 frame cycles (j = 0 to 59), the pulse counts are exactly 20 for `stb_third`, 30 for `stb_half`, 15 for `stb_quarter` and 24 for `stb_two5`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root clock; every strobe is a pattern on this clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all counters and strobes |
| flash_fast_sel | input | 1 | Control-register bit: 1 selects the two-in-five source for the flash strobe, 0 selects the quarter source |
| stb_third | output | 1 | Enable at one third of the root rate |
| stb_half | output | 1 | Enable at one half of the root rate |
| stb_quarter | output | 1 | Enable at one quarter of the root rate, derived from the half enable |
| stb_two5 | output | 1 | Enable two times in every five root cycles |
| stb_flash | output | 1 | Flash enable, taken from the quarter or the two-in-five source |

## Verification
The hardest case to reach from the ports is a select change that lands inside a 20-cycle window. Such a change must stay invisible until the next cycle where the five-cycle frame and the quarter pulse line up. To reach it, the stimulus toggles the select bit at several intervals that do not divide 20 (7, 3 and 13 cycles). This puts changes at many different phases of the window. The behavioural model in the bench latches its own copy of the select only on frame cycles that are multiples of 20, so any early or late switch in the design shows up as a mismatch on `stb_flash`. A reset in the middle of a run, with the select held at 0, confirms that the phase and the select both restart from their reset values.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

    // Sequencer: one settling cycle after reset, then free-running.
    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    // Flash strobe source.
    typedef enum logic {
        SRC_CORE = 1'b0,
        SRC_FAST = 1'b1
    } src_state_t;

    // Divider moduli and firing patterns (bit i set = fire on phase i).
    localparam int unsigned THIRD_MOD   = 3;
    localparam logic [2:0]  THIRD_PAT   = 3'b001;
    localparam int unsigned HALF_MOD    = 2;
    localparam logic [1:0]  HALF_PAT    = 2'b01;
    localparam int unsigned QUART_MOD   = 2;
    localparam logic [1:0]  QUART_PAT   = 2'b01;
    localparam int unsigned TWO5_MOD    = 5;
    localparam logic [4:0]  TWO5_PAT    = 5'b00101;

endpackage

// File: rtl/ratio_phase.sv
// Phase counter that advances when adv_i is high and fires on the phases
// marked in PATTERN. tick_o and start_o are combinational and can be
// chained into another instance; strobe_o is the registered tick.
module ratio_phase #(
    parameter int unsigned        MOD     = 3,
    parameter logic [MOD-1:0]     PATTERN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic tick_o,
    output logic start_o,
    output logic strobe_o
);
    localparam int unsigned CW   = (MOD > 1) ? $clog2(MOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(MOD - 1);

    logic [CW-1:0] phase_q;
    logic          hit;

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < int'(MOD); i++) begin
            if (phase_q == CW'(i)) hit = PATTERN[i];
        end
    end

    assign tick_o  = adv_i & hit;
    assign start_o = adv_i & (phase_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= '0;
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= tick_o;
            if (adv_i) begin
                phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_src_sel.sv
// Chooses the flash strobe source; the select is taken only on boundary_i.
module flash_src_sel
    import strobe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boundary_i,
    input  logic sel_i,
    input  logic fast_tick_i,
    input  logic core_tick_i,
    output logic strobe_o
);
    src_state_t src_q, src_d;
    logic       use_fast;

    // Next-state process.
    always_comb begin
        src_d = src_q;
        unique case (src_q)
            SRC_CORE: if (boundary_i && sel_i)  src_d = SRC_FAST;
            SRC_FAST: if (boundary_i && !sel_i) src_d = SRC_CORE;
            default:  src_d = SRC_CORE;
        endcase
    end

    // Output selection: on a boundary the new choice applies at once.
    always_comb begin
        use_fast = boundary_i ? sel_i : (src_q == SRC_FAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= SRC_CORE;
            strobe_o <= 1'b0;
        end else begin
            src_q    <= src_d;
            strobe_o <= use_fast ? fast_tick_i : core_tick_i;
        end
    end

endmodule

// File: rtl/frac_strobe_gen.sv
module frac_strobe_gen
    import strobe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flash_fast_sel,
    output logic stb_third,
    output logic stb_half,
    output logic stb_quarter,
    output logic stb_two5,
    output logic stb_flash
);
    seq_state_t state_q, state_d;
    logic       run;

    logic third_tick, third_start;
    logic half_tick,  half_start;
    logic quart_tick, quart_start;
    logic two5_tick,  two5_start;
    logic boundary;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Next state and outputs of the sequencer.
    always_comb begin
        state_d = state_q;
        run     = 1'b0;
        unique case (state_q)
            ST_HOLD: state_d = ST_RUN;
            ST_RUN:  run     = 1'b1;
            default: state_d = ST_HOLD;
        endcase
    end

    ratio_phase #(.MOD(THIRD_MOD), .PATTERN(THIRD_PAT)) u_third (
        .clk(clk), .rst_n(rst_n), .adv_i(run),
        .tick_o(third_tick), .start_o(third_start), .strobe_o(stb_third)
    );

    ratio_phase #(.MOD(HALF_MOD), .PATTERN(HALF_PAT)) u_half (
        .clk(clk), .rst_n(rst_n), .adv_i(run),
        .tick_o(half_tick), .start_o(half_start), .strobe_o(stb_half)
    );

    // Quarter rate: counts half-rate ticks, not root cycles.
    ratio_phase #(.MOD(QUART_MOD), .PATTERN(QUART_PAT)) u_quarter (
        .clk(clk), .rst_n(rst_n), .adv_i(half_tick),
        .tick_o(quart_tick), .start_o(quart_start), .strobe_o(stb_quarter)
    );

    ratio_phase #(.MOD(TWO5_MOD), .PATTERN(TWO5_PAT)) u_two5 (
        .clk(clk), .rst_n(rst_n), .adv_i(run),
        .tick_o(two5_tick), .start_o(two5_start), .strobe_o(stb_two5)
    );

    // A five-cycle frame start that is also a quarter pulse: every 20 cycles.
    assign boundary = two5_start & quart_tick;

    flash_src_sel u_flash (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary),
        .sel_i(flash_fast_sel), .fast_tick_i(two5_tick),
        .core_tick_i(quart_tick), .strobe_o(stb_flash)
    );

    logic unused_starts;
    assign unused_starts = third_start ^ half_start ^ quart_start;

endmodule

// File: rtl/strobe_gen_chk.sv
module strobe_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic stb_third,
    input logic stb_half,
    input logic stb_quarter,
    input logic stb_two5,
    input logic stb_flash
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 2'd2) |-> !(stb_third | stb_half | stb_quarter | stb_two5 | stb_flash));

    // R2
    third_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_third |=> !stb_third ##1 !stb_third);

    // R3
    half_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_half |=> !stb_half);

    // R4
    quarter_in_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_quarter |-> stb_half);

    // R5
    two5_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_two5 |=> !stb_two5);

    // R6
    flash_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_flash |-> (stb_quarter || stb_two5));

endmodule

bind frac_strobe_gen strobe_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .stb_third(stb_third), .stb_half(stb_half), .stb_quarter(stb_quarter),
    .stb_two5(stb_two5), .stb_flash(stb_flash)
);

// File: tb/frac_strobe_gen_bench.sv
module frac_strobe_gen_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b1;
    logic stb_third, stb_half, stb_quarter, stb_two5, stb_flash;

    int checks = 0;
    int errors = 0;
    int n = 0;          // rising edges since reset release
    bit msel = 1'b0;    // model's latched select
    int cnt3 = 0, cnt2 = 0, cnt4 = 0, cnt5 = 0;

    always #10 clk = ~clk;

    frac_strobe_gen u_frac_strobe_gen (
        .clk(clk), .rst_n(rst_n), .flash_fast_sel(sel),
        .stb_third(stb_third), .stb_half(stb_half), .stb_quarter(stb_quarter),
        .stb_two5(stb_two5), .stb_flash(stb_flash)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, n);
        end
    endtask

    task automatic chk_all_zero(input string tag);
        chk({tag, " stb_third"},   stb_third,   0);
        chk({tag, " stb_half"},    stb_half,    0);
        chk({tag, " stb_quarter"}, stb_quarter, 0);
        chk({tag, " stb_two5"},    stb_two5,    0);
        chk({tag, " stb_flash"},   stb_flash,   0);
    endtask

    // One root cycle: compare at the falling edge, then maybe move the select.
    task automatic step(input int toggle_every);
        bit sel_at_edge;
        int j;
        bit e3, e2, e4, e5, ef;
        @(negedge clk);
        n++;
        sel_at_edge = sel;
        if (n <= 1) begin
            chk_all_zero("R1 settle");
        end else begin
            j  = n - 2;
            if (j % 20 == 0) msel = sel_at_edge;   // R7: latch only here
            e3 = (j % 3 == 0);
            e2 = (j % 2 == 0);
            e4 = (j % 4 == 0);
            e5 = (j % 5 == 0) || (j % 5 == 2);
            ef = msel ? e5 : e4;
            chk(j == 0 ? "R1 first" : "R2 stb_third", stb_third, e3);
            chk("R3 stb_half",    stb_half,    e2);
            chk("R4 stb_quarter", stb_quarter, e4);
            chk("R5 stb_two5",    stb_two5,    e5);
            chk(msel ? "R6 flash fast (R7 latch)" : "R6 flash core (R7 latch)", stb_flash, ef);
            if (j < 60) begin
                cnt3 += stb_third;  cnt2 += stb_half;
                cnt4 += stb_quarter; cnt5 += stb_two5;
            end
            if (j == 59) begin
                chk("R8 count third",   cnt3, 20);
                chk("R8 count half",    cnt2, 30);
                chk("R8 count quarter", cnt4, 15);
                chk("R8 count two5",    cnt5, 24);
            end
        end
        if (toggle_every > 0 && (n % toggle_every) == 0) sel = ~sel;
    endtask

    initial begin
        // R1: outputs quiet while reset is held
        repeat (3) begin
            @(negedge clk);
            chk_all_zero("R1 in reset");
        end
        rst_n = 1'b1;
        n = 0;
        // Fixed select, window count (R8) and plain patterns
        for (int k = 0; k < 70; k++) step(0);
        // R7: select moves at many phases of the 20-cycle window
        for (int k = 0; k < 120; k++) step(7);
        for (int k = 0; k < 60; k++)  step(3);
        for (int k = 0; k < 80; k++)  step(13);
        // Reset mid-run, restart with core source
        @(negedge clk);
        rst_n = 1'b0;
        sel = 1'b0;
        @(negedge clk);
        chk_all_zero("R1 mid-run reset");
        rst_n = 1'b1;
        n = 0;
        msel = 1'b0;
        cnt3 = 0; cnt2 = 0; cnt4 = 0; cnt5 = 0;
        for (int k = 0; k < 90; k++) step(11);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule